// File: doc/BRIEF.md
# Prescaled Down-Counter with Repeat Modes

This block is a down-counter intended to run from a slow clock. A power-of-two prescaler turns the clock into count ticks. On every tick the count steps down by one. When a tick finds the count at zero, that tick is an underflow: the count reloads from a top value, and the repeat counters advance as the selected repeat mode requires.

The repeat mode decides when the counter stops by itself. It can run freely, stop after a set number of wraps, chain a second repeat count into the first, or wait until two repeat counters have both reached zero. The counter can also reload from a fixed top or from compare value 0. Compare value 0 can optionally be replaced by compare value 1 each time repeat counter 0 runs out.

Single-cycle strobes report underflow, the two compare matches and the two repeat-counter-zero events. The same five events set sticky flags. The flags are masked by an enable vector to form one interrupt line. The surrounding register interface drives the configuration inputs and the write strobes.

Top module: `lptmr_core`

## Requirements
- R1: After a synchronous reset, count_o, rep0_o, rep1_o, flags_o and every strobe read 0, and running_o and irq_o are low.
- R2: While running, a count tick occurs once every 2^n clock cycles, where n is presc_i. Codes above 8 behave as n = 8. After a start, the first tick comes 2^n cycles after the edge that samples start_i.
- R3: A tick that finds the count at zero is an underflow. It pulses uf_o and reloads the count with 0x00FFFF when topsel_i is 0, or with compare value 0 when topsel_i is 1. A tick at any other count decrements it by one.
- R4: In mode 0 the counter keeps running through underflows. A stop_i pulse clears running_o at the next edge, and the count then holds. A clear_i pulse sets the count to 0.
- R5: In mode 1 the counter stops after max(rep0,1) underflows. running_o clears on the edge of the last underflow, and rep0_zero_o pulses once.
- R6: In mode 2, when repeat counter 0 runs out and repeat counter 1 has been written since its last load, repeat counter 1 is copied into repeat counter 0 and counting continues. Otherwise the counter stops. The total is max(rep0,1)+max(rep1,1) underflows, with two rep0_zero_o pulses.
- R7: In mode 3 both repeat counters decrement on each underflow, saturating at 0. The counter stops after max(rep0,rep1,1) underflows. Each of rep0_zero_o and rep1_zero_o pulses once when its counter steps from 1 to 0.
- R8: With buftop_i set, compare value 0 (cmp0_o) takes the value of cmp1_i at each repeat-counter-0 zero event. With buftop_i clear, only cmp0_wr_i changes it.
- R9: cmp0_hit_o and cmp1_hit_o pulse on a tick that finds the count equal to the respective compare value.
- R10: flags_o bit 0 records compare 0 match, bit 1 compare 1 match, bit 2 underflow, bit 3 repeat counter 0 zero and bit 4 repeat counter 1 zero. Each flag stays set until a 1 on the same bit of flag_clr_i clears it.
- R11: irq_o is high, one edge after the inputs change, exactly when any flag is set whose bit in irq_en_i is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Count-domain clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start pulse; restarts the prescaler |
| stop_i | input | 1 | Stop pulse; wins over start_i |
| clear_i | input | 1 | Sets the count to 0 |
| mode_i | input | 2 | Repeat mode 0..3 |
| topsel_i | input | 1 | Reload from compare value 0 when 1 |
| buftop_i | input | 1 | Reload compare value 0 from compare value 1 on rep0 zero |
| presc_i | input | 4 | Prescaler exponent |
| cmp0_wr_i | input | 1 | Write strobe for compare value 0 |
| cmp0_wdata_i | input | 24 | Compare value 0 write data |
| cmp1_i | input | 24 | Compare value 1 |
| rep0_wr_i | input | 1 | Write strobe for repeat counter 0 |
| rep0_wdata_i | input | 8 | Repeat counter 0 write data |
| rep1_wr_i | input | 1 | Write strobe for repeat counter 1 |
| rep1_wdata_i | input | 8 | Repeat counter 1 write data |
| irq_en_i | input | 5 | Interrupt enable mask, same layout as flags |
| flag_clr_i | input | 5 | Write-one-to-clear for flags |
| count_o | output | 24 | Live count |
| cmp0_o | output | 24 | Current compare value 0 |
| rep0_o | output | 8 | Repeat counter 0 |
| rep1_o | output | 8 | Repeat counter 1 |
| running_o | output | 1 | Counter running |
| uf_o | output | 1 | Underflow strobe |
| cmp0_hit_o | output | 1 | Compare 0 match strobe |
| cmp1_hit_o | output | 1 | Compare 1 match strobe |
| rep0_zero_o | output | 1 | Repeat counter 0 zero strobe |
| rep1_zero_o | output | 1 | Repeat counter 1 zero strobe |
| flags_o | output | 5 | Sticky event flags |
| irq_o | output | 1 | Masked interrupt |

## Verification
The assertions assume three things about the inputs. Reset is held for at least two edges. mode_i, topsel_i and buftop_i do not change in the cycle of an underflow they qualify. The compare-0 and repeat-0 write strobes are not used on the edge where the counter stops. The bench meets these conditions by changing configuration and writing values only while the counter is stopped and after a clear pulse. It then leaves every configuration input steady until running_o falls. Random cases draw short tops, small repeat counts and low prescaler codes, so each run ends within a few hundred cycles.

// File: rtl/lptmr_pkg.sv
package lptmr_pkg;
  typedef enum logic [1:0] {
    RM_FREE    = 2'd0,
    RM_ONESHOT = 2'd1,
    RM_CHAIN   = 2'd2,
    RM_DUAL    = 2'd3
  } rep_mode_e;

  localparam int NFLAGS  = 5;
  localparam int FL_CMP0 = 0;
  localparam int FL_CMP1 = 1;
  localparam int FL_UF   = 2;
  localparam int FL_REP0 = 3;
  localparam int FL_REP1 = 4;
endpackage

// File: rtl/lptmr_presc.sv
module lptmr_presc #(
  parameter int PW     = 4,
  parameter int MAXEXP = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          run,
  input  logic          restart,
  input  logic [PW-1:0] code,
  output logic          tick
);
  localparam logic [PW-1:0] MAXC = PW'(MAXEXP);

  logic [MAXEXP-1:0] div_q;
  logic [MAXEXP-1:0] mask;
  logic [PW-1:0]     expo;

  assign expo = (code > MAXC) ? MAXC : code;

  always_comb begin
    for (int i = 0; i < MAXEXP; i++) mask[i] = (i < int'(expo));
  end

  assign tick = run && ((div_q & mask) == mask);

  always_ff @(posedge clk) begin
    if (rst || restart) div_q <= '0;
    else if (run)       div_q <= div_q + MAXEXP'(1);
  end
endmodule

// File: rtl/lptmr_repeat.sv
module lptmr_repeat
  import lptmr_pkg::*;
#(
  parameter int RW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  rep_mode_e     mode,
  input  logic          uf,
  input  logic          wr0,
  input  logic [RW-1:0] wdata0,
  input  logic          wr1,
  input  logic [RW-1:0] wdata1,
  output logic [RW-1:0] rep0,
  output logic [RW-1:0] rep1,
  output logic          evt0,
  output logic          evt1,
  output logic          halt
);
  logic [RW-1:0] r0_q, r1_q;
  logic          pend_q;
  logic          r0_low, r1_low, r0_one, r1_one, load_chain;
  logic [RW-1:0] r0_dec, r1_dec;

  assign r0_low = (r0_q <= RW'(1));
  assign r1_low = (r1_q <= RW'(1));
  assign r0_one = (r0_q == RW'(1));
  assign r1_one = (r1_q == RW'(1));
  assign r0_dec = (r0_q != '0) ? r0_q - RW'(1) : r0_q;
  assign r1_dec = (r1_q != '0) ? r1_q - RW'(1) : r1_q;
  assign load_chain = uf && (mode == RM_CHAIN) && r0_low && pend_q;

  always_comb begin
    evt0 = 1'b0;
    evt1 = 1'b0;
    halt = 1'b0;
    if (uf) begin
      unique case (mode)
        RM_FREE: ;
        RM_ONESHOT: begin
          evt0 = r0_low;
          halt = r0_low;
        end
        RM_CHAIN: begin
          evt0 = r0_low;
          halt = r0_low && !pend_q;
        end
        RM_DUAL: begin
          evt0 = r0_one;
          evt1 = r1_one;
          halt = r0_low && r1_low;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      r0_q   <= '0;
      r1_q   <= '0;
      pend_q <= 1'b0;
    end else begin
      if (wr0)                     r0_q <= wdata0;
      else if (load_chain)         r0_q <= r1_q;
      else if (uf && mode != RM_FREE) r0_q <= r0_dec;

      if (wr1)                       r1_q <= wdata1;
      else if (uf && mode == RM_DUAL) r1_q <= r1_dec;

      if (wr1)             pend_q <= 1'b1;
      else if (load_chain) pend_q <= 1'b0;
    end
  end

  assign rep0 = r0_q;
  assign rep1 = r1_q;
endmodule

// File: rtl/lptmr_flags.sv
module lptmr_flags #(
  parameter int N = 5
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] set,
  input  logic [N-1:0] clr,
  input  logic [N-1:0] en,
  output logic [N-1:0] flags,
  output logic         irq
);
  logic [N-1:0] flags_q, flags_d;
  logic         irq_q;

  assign flags_d = (flags_q & ~clr) | set;

  always_ff @(posedge clk) begin
    if (rst) begin
      flags_q <= '0;
      irq_q   <= 1'b0;
    end else begin
      flags_q <= flags_d;
      irq_q   <= |(flags_d & en);
    end
  end

  assign flags = flags_q;
  assign irq   = irq_q;
endmodule

// File: rtl/lptmr_core.sv
module lptmr_core
  import lptmr_pkg::*;
#(
  parameter int          CW       = 24,
  parameter int          RW       = 8,
  parameter int          PW       = 4,
  parameter int          MAXEXP   = 8,
  parameter int unsigned FREE_TOP = 32'h0000FFFF
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  input  logic              stop_i,
  input  logic              clear_i,
  input  logic [1:0]        mode_i,
  input  logic              topsel_i,
  input  logic              buftop_i,
  input  logic [PW-1:0]     presc_i,
  input  logic              cmp0_wr_i,
  input  logic [CW-1:0]     cmp0_wdata_i,
  input  logic [CW-1:0]     cmp1_i,
  input  logic              rep0_wr_i,
  input  logic [RW-1:0]     rep0_wdata_i,
  input  logic              rep1_wr_i,
  input  logic [RW-1:0]     rep1_wdata_i,
  input  logic [NFLAGS-1:0] irq_en_i,
  input  logic [NFLAGS-1:0] flag_clr_i,
  output logic [CW-1:0]     count_o,
  output logic [CW-1:0]     cmp0_o,
  output logic [RW-1:0]     rep0_o,
  output logic [RW-1:0]     rep1_o,
  output logic              running_o,
  output logic              uf_o,
  output logic              cmp0_hit_o,
  output logic              cmp1_hit_o,
  output logic              rep0_zero_o,
  output logic              rep1_zero_o,
  output logic [NFLAGS-1:0] flags_o,
  output logic              irq_o
);
  localparam logic [CW-1:0] FIXED_TOP = CW'(FREE_TOP);

  rep_mode_e         mode;
  logic              run_q, tick, uf, halt, evt0, evt1, m0, m1, go;
  logic [CW-1:0]     cnt_q, cmp0_q, reload;
  logic [NFLAGS-1:0] evset;
  logic [4:0]        strobe_q;

  assign mode   = rep_mode_e'(mode_i);
  assign go     = start_i && !stop_i;
  assign uf     = tick && (cnt_q == '0);
  assign m0     = tick && (cnt_q == cmp0_q);
  assign m1     = tick && (cnt_q == cmp1_i);
  assign reload = topsel_i ? cmp0_q : FIXED_TOP;

  lptmr_presc #(.PW(PW), .MAXEXP(MAXEXP)) presc_i0 (
    .clk(clk), .rst(rst), .run(run_q), .restart(go), .code(presc_i), .tick(tick)
  );

  lptmr_repeat #(.RW(RW)) rep_i0 (
    .clk(clk), .rst(rst), .mode(mode), .uf(uf),
    .wr0(rep0_wr_i), .wdata0(rep0_wdata_i),
    .wr1(rep1_wr_i), .wdata1(rep1_wdata_i),
    .rep0(rep0_o), .rep1(rep1_o), .evt0(evt0), .evt1(evt1), .halt(halt)
  );

  always_comb begin
    evset          = '0;
    evset[FL_CMP0] = m0;
    evset[FL_CMP1] = m1;
    evset[FL_UF]   = uf;
    evset[FL_REP0] = evt0;
    evset[FL_REP1] = evt1;
  end

  lptmr_flags #(.N(NFLAGS)) flags_i0 (
    .clk(clk), .rst(rst), .set(evset), .clr(flag_clr_i), .en(irq_en_i),
    .flags(flags_o), .irq(irq_o)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q    <= 1'b0;
      cnt_q    <= '0;
      cmp0_q   <= '0;
      strobe_q <= '0;
    end else begin
      if (stop_i)     run_q <= 1'b0;
      else if (go)    run_q <= 1'b1;
      else if (halt)  run_q <= 1'b0;

      if (clear_i)    cnt_q <= '0;
      else if (uf)    cnt_q <= reload;
      else if (tick)  cnt_q <= cnt_q - CW'(1);

      if (cmp0_wr_i)              cmp0_q <= cmp0_wdata_i;
      else if (buftop_i && evt0)  cmp0_q <= cmp1_i;

      strobe_q <= {evt1, evt0, uf, m1, m0};
    end
  end

  assign count_o     = cnt_q;
  assign cmp0_o      = cmp0_q;
  assign running_o   = run_q;
  assign cmp0_hit_o  = strobe_q[0];
  assign cmp1_hit_o  = strobe_q[1];
  assign uf_o        = strobe_q[2];
  assign rep0_zero_o = strobe_q[3];
  assign rep1_zero_o = strobe_q[4];
endmodule

// File: rtl/lptmr_core_chk.sv
module lptmr_core_chk #(
  parameter int CW = 24,
  parameter int RW = 8,
  parameter int NF = 5
) (
  input logic          clk,
  input logic          rst,
  input logic          stop_i,
  input logic [1:0]    mode_i,
  input logic          topsel_i,
  input logic          buftop_i,
  input logic          cmp0_wr_i,
  input logic          rep0_wr_i,
  input logic [NF-1:0] irq_en_i,
  input logic [NF-1:0] flag_clr_i,
  input logic [CW-1:0] count_o,
  input logic [CW-1:0] cmp0_o,
  input logic [RW-1:0] rep0_o,
  input logic          running_o,
  input logic          uf_o,
  input logic [NF-1:0] flags_o,
  input logic          irq_o
);
  a_r4_stop_halts: assert property (@(posedge clk) disable iff (rst)
    stop_i |=> !running_o);

  a_r3_uf_only_running: assert property (@(posedge clk) disable iff (rst)
    uf_o |-> $past(running_o));

  a_r3_reload_value: assert property (@(posedge clk) disable iff (rst)
    (uf_o && $stable(topsel_i) && !$past(buftop_i) && !$past(cmp0_wr_i))
      |-> count_o == (topsel_i ? $past(cmp0_o) : CW'(32'h0000FFFF)));

  a_r5_oneshot_end: assert property (@(posedge clk) disable iff (rst)
    ($fell(running_o) && !$past(stop_i) && $past(mode_i) == 2'd1 && !$past(rep0_wr_i))
      |-> (uf_o && rep0_o == '0));

  a_r10_sticky: assert property (@(posedge clk) disable iff (rst)
    ((($past(flags_o) & ~$past(flag_clr_i)) & ~flags_o) == '0));

  a_r11_irq_mask: assert property (@(posedge clk) disable iff (rst)
    irq_o == |(flags_o & $past(irq_en_i)));
endmodule

bind lptmr_core lptmr_core_chk #(.CW(CW), .RW(RW), .NF(lptmr_pkg::NFLAGS)) chk_i (
  .clk(clk), .rst(rst), .stop_i(stop_i), .mode_i(mode_i), .topsel_i(topsel_i),
  .buftop_i(buftop_i), .cmp0_wr_i(cmp0_wr_i), .rep0_wr_i(rep0_wr_i),
  .irq_en_i(irq_en_i), .flag_clr_i(flag_clr_i), .count_o(count_o),
  .cmp0_o(cmp0_o), .rep0_o(rep0_o), .running_o(running_o), .uf_o(uf_o),
  .flags_o(flags_o), .irq_o(irq_o)
);

// File: tb/lptmr_core_tb_top.sv
module lptmr_core_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 150000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start_i = 0, stop_i = 0, clear_i = 0;
  logic [1:0]  mode_i = 0;
  logic        topsel_i = 0, buftop_i = 0;
  logic [3:0]  presc_i = 0;
  logic        cmp0_wr_i = 0, rep0_wr_i = 0, rep1_wr_i = 0;
  logic [23:0] cmp0_wdata_i = 0, cmp1_i = 0;
  logic [7:0]  rep0_wdata_i = 0, rep1_wdata_i = 0;
  logic [4:0]  irq_en_i = 0, flag_clr_i = 0;
  logic [23:0] count_o, cmp0_o;
  logic [7:0]  rep0_o, rep1_o;
  logic        running_o, uf_o, cmp0_hit_o, cmp1_hit_o, rep0_zero_o, rep1_zero_o, irq_o;
  logic [4:0]  flags_o;

  int n_chk = 0, n_fail = 0, cyc = 0;
  int c_uf, c_m0, c_m1, c_z0, c_z1, c_run;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  lptmr_core dut_i (.*);

  always @(negedge clk) begin
    if (uf_o)        c_uf++;
    if (cmp0_hit_o)  c_m0++;
    if (cmp1_hit_o)  c_m1++;
    if (rep0_zero_o) c_z0++;
    if (rep1_zero_o) c_z1++;
    if (running_o)   c_run++;
  end

  task automatic check(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int max1(int v); return (v < 1) ? 1 : v; endfunction
  function automatic int period(int code); return 1 << ((code > 8) ? 8 : code); endfunction
  function automatic int exp_uf(int mode, int a, int b);
    if (mode == 1) return max1(a);
    if (mode == 2) return max1(a) + max1(b);
    return max1((a > b) ? a : b);
  endfunction
  function automatic int exp_z0(int mode, int a);
    if (mode == 3) return (a >= 1) ? 1 : 0;
    return (mode == 2) ? 2 : 1;
  endfunction
  function automatic int exp_match(int v, int top, int u);
    return (v <= top) ? (u - 1) + ((v == 0) ? 1 : 0) : 0;
  endfunction

  task automatic prep(int mode, int code, bit tsel, bit btop, int top, int c, int a, int b);
    @(negedge clk);
    mode_i = 2'(mode); presc_i = 4'(code); topsel_i = tsel; buftop_i = btop;
    cmp1_i = 24'(c);
    cmp0_wr_i = 1; cmp0_wdata_i = 24'(top);
    rep0_wr_i = 1; rep0_wdata_i = 8'(a);
    rep1_wr_i = 1; rep1_wdata_i = 8'(b);
    clear_i = 1; flag_clr_i = 5'h1F;
    @(negedge clk);
    cmp0_wr_i = 0; rep0_wr_i = 0; rep1_wr_i = 0; clear_i = 0; flag_clr_i = 0;
    @(negedge clk);
    c_uf = 0; c_m0 = 0; c_m1 = 0; c_z0 = 0; c_z1 = 0; c_run = 0;
  endtask

  task automatic pulse_start;
    @(negedge clk); start_i = 1;
    @(negedge clk); start_i = 0;
  endtask

  task automatic wait_stop;
    int g = 0;
    while (running_o && g < 6000) begin @(negedge clk); g++; end
    @(negedge clk);
  endtask

  task automatic run_case(int mode, int code, int top, int c, int a, int b);
    int u;
    int ef;
    prep(mode, code, 1, 0, top, c, a, b);
    pulse_start();
    wait_stop();
    u = exp_uf(mode, a, b);
    check("R3 underflow count", c_uf, u);
    check("R2/R5 running cycles", c_run, period(code) * (1 + (u - 1) * (top + 1)));
    if (mode == 1) check("R5 rep0 zero", c_z0, exp_z0(mode, a));
    if (mode == 2) check("R6 rep0 zero", c_z0, exp_z0(mode, a));
    if (mode == 3) begin
      check("R7 rep0 zero", c_z0, exp_z0(mode, a));
      check("R7 rep1 zero", c_z1, (b >= 1) ? 1 : 0);
    end
    check("R9 cmp0 matches", c_m0, exp_match(top, top, u));
    check("R9 cmp1 matches", c_m1, exp_match(c, top, u));
    ef = ((exp_match(top, top, u) > 0) ? 1 : 0) | ((exp_match(c, top, u) > 0) ? 2 : 0) | 4 |
         ((exp_z0(mode, a) > 0) ? 8 : 0) | ((mode == 3 && b >= 1) ? 16 : 0);
    check("R10 flags", int'(flags_o), ef);
  endtask

  initial begin
    forever begin
      @(posedge clk); cyc++;
      if (cyc > WATCHDOG && !done) begin
        n_fail++; n_chk++;
        $display("FAIL watchdog actual=%0d expected<%0d", cyc, WATCHDOG);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
      end
    end
  end

  initial begin
    int seen;
    repeat (5) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1 reset state
    check("R1 count", int'(count_o), 0);
    check("R1 running", int'(running_o), 0);
    check("R1 flags", int'(flags_o), 0);
    check("R1 irq/strobes", int'({irq_o, uf_o, cmp0_hit_o, cmp1_hit_o, rep0_zero_o, rep1_zero_o}), 0);
    check("R1 repeat", int'({rep0_o, rep1_o}), 0);

    // R3 fixed top, R4 free run, stop and hold
    prep(0, 0, 0, 0, 5, 9, 0, 0);
    pulse_start();
    @(negedge clk);
    check("R3 reload fixed top", int'(count_o), 24'h00FFFF);
    check("R3 uf strobe", int'(uf_o), 1);
    @(negedge clk);
    check("R3 decrement", int'(count_o), 24'h00FFFE);
    prep(0, 0, 1, 0, 1, 9, 0, 0);
    pulse_start();
    repeat (30) @(negedge clk);
    check("R4 free still running", int'(running_o), 1);
    @(negedge clk); stop_i = 1;
    @(negedge clk); stop_i = 0;
    check("R4 stopped", int'(running_o), 0);
    seen = int'(count_o);
    repeat (4) @(negedge clk);
    check("R4 count holds", int'(count_o), seen);
    @(negedge clk); clear_i = 1;
    @(negedge clk); clear_i = 0;
    check("R4 clear", int'(count_o), 0);

    // R2 prescaler, including codes above 8
    run_case(1, 3, 1, 9, 2, 0);
    run_case(1, 12, 0, 9, 2, 0);
    run_case(1, 9, 0, 9, 2, 0);

    // R8 buffered compare value
    prep(1, 0, 1, 1, 2, 5, 2, 0);
    pulse_start(); wait_stop();
    check("R8 cmp0 from cmp1", int'(cmp0_o), 5);
    prep(1, 0, 1, 0, 2, 5, 2, 0);
    pulse_start(); wait_stop();
    check("R8 cmp0 unchanged", int'(cmp0_o), 2);

    // Directed repeat-mode corners: R5 zero count, R6 chain, R7 dual
    run_case(1, 0, 2, 1, 0, 0);
    run_case(2, 0, 2, 1, 0, 3);
    run_case(3, 0, 1, 0, 0, 3);
    run_case(3, 1, 1, 1, 4, 0);

    // Random cases with a fixed seed
    void'($urandom(32'h1234));
    for (int i = 0; i < 20; i++) begin
      run_case(1 + int'($urandom_range(0, 2)), int'($urandom_range(0, 2)),
               int'($urandom_range(0, 5)), int'($urandom_range(0, 6)),
               int'($urandom_range(0, 4)), int'($urandom_range(0, 4)));
    end

    // R10 clearing and R11 masking
    run_case(1, 0, 2, 1, 2, 0);
    check("R10 flags all but rep1", int'(flags_o), 5'b01111);
    @(negedge clk); flag_clr_i = 5'b00100;
    @(negedge clk); flag_clr_i = 0;
    check("R10 w1c underflow bit", int'(flags_o), 5'b01011);
    irq_en_i = 5'b00100;
    @(negedge clk);
    check("R11 masked irq low", int'(irq_o), 0);
    irq_en_i = 5'b00001;
    @(negedge clk);
    check("R11 enabled irq high", int'(irq_o), 1);
    @(negedge clk); flag_clr_i = 5'h1F;
    @(negedge clk); flag_clr_i = 0;
    check("R11 irq after clear", int'(irq_o), 0);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule